// File: doc/BRIEF.md
# Multi-Source Watchdog Timer

This block watches for a stalled program. It counts ticks from one of three sources and, when the count runs out before software clears it, raises a one-cycle request. The sources are a free-running watchdog oscillator tick, a divide-by-four of the block's own clock (the system clock), and a 32768 Hz real-time tick. The two external ticks arrive as one-cycle strobes that are already synchronous to `clk`. The quarter-rate system tick is made inside the block.

Counting runs through a 256-step base stage and then a binary prescaler. The prescaler lengthens the period by 2^N, where N is set by a 3-bit ratio input. Software writes to the clear strobe to restart the count. When the count expires, the block raises a reset request if the system is running, or a wake-up request if the system is halted.

The block has no data stream, so every pin is a plain control or status level. There is no back-pressure.

Top module: `wdog_multi_src`

## Requirements
- R1: `src_sel` encoding: 0 selects `osc_tick`, 1 selects the internal clk/4 tick, 2 selects `rtc_tick`, and 3 selects no source. Ticks from any source that is not selected have no effect on the count.
- R2: With source 1 and ratio 0, an expiry request is visible exactly 1024 clock edges after the first edge with counting enabled.
- R3: With ratio 0, the time-out is 256 ticks of the selected source. The request is visible right after the edge that takes the 256th tick.
- R4: With ratio N (0 to 7), the time-out is 256 × 2^N ticks of the selected source.
- R5: When `halt` is low at the expiring edge, `rst_req` goes high for exactly one cycle and `wake_req` stays low.
- R6: When `halt` is high at the expiring edge, `wake_req` goes high for exactly one cycle and `rst_req` stays low.
- R7: `clr` high at an edge zeroes every counter and suppresses any expiry at that same edge. Counting resumes at the next edge, so the next request follows the clear by 256 × 2^N ticks.
- R8: While `en` is low, every counter is held at zero and neither request is raised. After reset, both requests are low.
- R9: An edge where `src_sel` differs from its value at the previous edge restarts the count in the same way as a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Watchdog enable |
| src_sel | input | 2 | Tick source select (see R1) |
| ratio | input | 3 | Prescaler exponent N, period × 2^N |
| clr | input | 1 | Clear strobe |
| halt | input | 1 | System is halted |
| osc_tick | input | 1 | Watchdog oscillator tick strobe |
| rtc_tick | input | 1 | 32768 Hz tick strobe |
| rst_req | output | 1 | One-cycle reset request |
| wake_req | output | 1 | One-cycle wake-up request |

## Verification
The assertions assume the tick strobes are synchronous to `clk`. They also assume `ratio` holds steady between restarts, since a change mid-count moves the expiry point.

The stimulus follows both rules. It changes `ratio` only while `en` is low, and it drives the ticks at the falling clock edge. Within those limits it holds ticks high continuously, which gives the fastest expiry and places the clear and the select change at chosen edges.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    SRC_OSC  = 2'd0,
    SRC_SYS4 = 2'd1,
    SRC_RTC  = 2'd2,
    SRC_NONE = 2'd3
  } wdog_src_e;
endpackage

// File: rtl/wdog_tick_sel.sv
module wdog_tick_sel
  import wdog_pkg::*;
#(
  parameter int DIV_W = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart_i,
  input  wdog_src_e  sel_i,
  input  logic       osc_i,
  input  logic       rtc_i,
  output logic       tick_o
);
  localparam logic [DIV_W-1:0] DIV_MAX = {DIV_W{1'b1}};

  logic [DIV_W-1:0] div_q;
  logic             sys_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         div_q <= '0;
    else if (restart_i) div_q <= '0;
    else                div_q <= div_q + 1'b1;
  end

  assign sys_tick = (div_q == DIV_MAX);

  always_comb begin
    unique case (sel_i)
      SRC_OSC:  tick_o = osc_i;
      SRC_SYS4: tick_o = sys_tick;
      SRC_RTC:  tick_o = rtc_i;
      default:  tick_o = 1'b0;
    endcase
  end

  p_sys_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == SRC_SYS4 && tick_o && !restart_i) |=> !tick_o);
endmodule

// File: rtl/wdog_base.sv
module wdog_base #(
  parameter int BASE_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic tick_i,
  output logic ovf_o
);
  localparam logic [BASE_W-1:0] BASE_MAX = {BASE_W{1'b1}};

  logic [BASE_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (tick_i)    cnt_q <= cnt_q + 1'b1;
  end

  assign ovf_o = tick_i && !restart_i && (cnt_q == BASE_MAX);

  p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> (cnt_q == '0));
  p_clr_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (cnt_q == '0));
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !restart_i) |=> $stable(cnt_q));
endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int RATIO_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart_i,
  input  logic               step_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               full_o
);
  localparam int PRE_W = (1 << RATIO_W) - 1;

  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] mask;

  for (genvar i = 0; i < PRE_W; i++) begin : g_mask
    assign mask[i] = (32'(ratio_i) > i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (step_i)    cnt_q <= cnt_q + 1'b1;
  end

  assign full_o = &(cnt_q | ~mask);

  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !restart_i) |=> (cnt_q == $past(cnt_q) + 1'b1));
  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (cnt_q == '0));
endmodule

// File: rtl/wdog_multi_src.sv
module wdog_multi_src
  import wdog_pkg::*;
#(
  parameter int BASE_W  = 8,
  parameter int RATIO_W = 3,
  parameter int DIV_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [1:0]         src_sel,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               clr,
  input  logic               halt,
  input  logic               osc_tick,
  input  logic               rtc_tick,
  output logic               rst_req,
  output logic               wake_req
);
  wdog_src_e sel_now;
  wdog_src_e sel_q;
  logic      restart;
  logic      tick;
  logic      base_ovf;
  logic      pre_full;
  logic      expire;

  assign sel_now = wdog_src_e'(src_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= SRC_OSC;
    else        sel_q <= sel_now;
  end

  assign restart = clr || !en || (sel_now != sel_q);

  wdog_tick_sel #(.DIV_W(DIV_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .restart_i(restart), .sel_i(sel_now),
    .osc_i(osc_tick), .rtc_i(rtc_tick), .tick_o(tick)
  );

  wdog_base #(.BASE_W(BASE_W)) u_base (
    .clk(clk), .rst_n(rst_n), .restart_i(restart), .tick_i(tick), .ovf_o(base_ovf)
  );

  wdog_prescale #(.RATIO_W(RATIO_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart_i(restart), .step_i(base_ovf),
    .ratio_i(ratio), .full_o(pre_full)
  );

  assign expire = base_ovf && pre_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req  <= 1'b0;
      wake_req <= 1'b0;
    end else begin
      rst_req  <= expire && !halt;
      wake_req <= expire && halt;
    end
  end

  p_rst_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  p_wake_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |=> !wake_req);
  p_halt_route_r6: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> !rst_req);
  p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!rst_req && !wake_req));
  p_clr_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!rst_req && !wake_req));
  p_sel_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_now != sel_q) |=> (!rst_req && !wake_req));
endmodule

// File: tb/sim_wdog_multi_src.sv
module sim_wdog_multi_src;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [1:0] src_sel = 2'd0;
  logic [2:0] ratio = 3'd0;
  logic       clr = 1'b0;
  logic       halt = 1'b0;
  logic       osc_tick = 1'b0;
  logic       rtc_tick = 1'b0;
  logic       rst_req;
  logic       wake_req;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  string cur_req = "R8";

  int m_phase = 0;
  int m_ticks = 0;
  int m_prev = 0;
  logic exp_rst = 1'b0;
  logic exp_wake = 1'b0;

  always #10 clk = ~clk;

  wdog_multi_src u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .src_sel(src_sel), .ratio(ratio),
    .clr(clr), .halt(halt), .osc_tick(osc_tick), .rtc_tick(rtc_tick),
    .rst_req(rst_req), .wake_req(wake_req)
  );

  // behavioural model: ticks since last restart against the time-out length
  always @(posedge clk) begin
    bit tk;
    bit fire;
    if (!rst_n) begin
      m_phase = 0; m_ticks = 0; m_prev = 0;
      exp_rst <= 1'b0; exp_wake <= 1'b0;
    end else begin
      fire = 1'b0;
      if (clr || !en || (int'(src_sel) != m_prev)) begin
        m_phase = 0; m_ticks = 0;
      end else begin
        case (src_sel)
          2'd0: tk = osc_tick;
          2'd1: tk = (m_phase == 3);
          2'd2: tk = rtc_tick;
          default: tk = 1'b0;
        endcase
        m_phase = (m_phase + 1) % 4;
        if (tk) begin
          m_ticks++;
          if (m_ticks == (256 << ratio)) begin
            fire = 1'b1; m_ticks = 0;
          end
        end
      end
      m_prev = int'(src_sel);
      exp_rst <= fire && !halt;
      exp_wake <= fire && halt;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      tests++;
      if (rst_req !== exp_rst || wake_req !== exp_wake) begin
        fails++;
        $display("FAIL %s: rst_req/wake_req=%b%b expected %b%b at cycle %0d",
                 cur_req, rst_req, wake_req, exp_rst, exp_wake, cycles);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      fails++;
      $display("FAIL watchdog: run hung, expected end before %0d cycles", 190000);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // restart, configure, then run n edges; clear or select change at given edge
  task automatic scen(input string req, input int sel, input int rat, input bit h,
                      input bit o, input bit r, input int n,
                      input int clr_at, input int chg_at, input int new_sel,
                      output int first_rst, output int first_wake,
                      output int n_rst, output int n_wake);
    cur_req = req;
    @(negedge clk); en = 1'b0;
    @(negedge clk);
    src_sel = 2'(sel); ratio = 3'(rat); halt = h; osc_tick = o; rtc_tick = r;
    @(negedge clk); en = 1'b1;
    first_rst = 0; first_wake = 0; n_rst = 0; n_wake = 0;
    for (int i = 1; i <= n; i++) begin
      clr = (i == clr_at);
      if (i == chg_at) src_sel = 2'(new_sel);
      @(negedge clk);
      if (rst_req) begin n_rst++; if (first_rst == 0) first_rst = i; end
      if (wake_req) begin n_wake++; if (first_wake == 0) first_wake = i; end
    end
    clr = 1'b0;
  endtask

  initial begin
    int fr, fw, nr, nw;
    repeat (3) @(negedge clk);
    check("R8", int'(rst_req), 0);
    check("R8", int'(wake_req), 0);
    rst_n = 1'b1;

    // R2: clk/4 source, ratio 0
    scen("R2", 1, 0, 0, 0, 0, 1100, 0, 0, 0, fr, fw, nr, nw);
    check("R2", fr, 1024);
    check("R5", nr, 1);
    // R3: rtc source at one tick per cycle
    scen("R3", 2, 0, 0, 0, 1, 300, 0, 0, 0, fr, fw, nr, nw);
    check("R3", fr, 256);
    // R1: oscillator source, rtc ticks ignored
    scen("R1", 0, 0, 0, 0, 1, 600, 0, 0, 0, fr, fw, nr, nw);
    check("R1", nr, 0);
    scen("R1", 0, 0, 0, 1, 0, 300, 0, 0, 0, fr, fw, nr, nw);
    check("R1", fr, 256);
    scen("R1", 3, 0, 0, 1, 1, 600, 0, 0, 0, fr, fw, nr, nw);
    check("R1", nr + nw, 0);
    // R4: prescaler ratios
    scen("R4", 0, 2, 0, 1, 0, 1100, 0, 0, 0, fr, fw, nr, nw);
    check("R4", fr, 1024);
    scen("R4", 2, 7, 0, 0, 1, 32800, 0, 0, 0, fr, fw, nr, nw);
    check("R4", fr, 32768);
    // R5: repeated pulses, each one cycle
    scen("R5", 0, 0, 0, 1, 0, 800, 0, 0, 0, fr, fw, nr, nw);
    check("R5", nr, 3);
    check("R5", nw, 0);
    // R6: halted gives wake-up
    scen("R6", 0, 0, 1, 1, 0, 300, 0, 0, 0, fr, fw, nr, nw);
    check("R6", fw, 256);
    check("R6", nr, 0);
    // R7: clear mid-count and clear on the expiring edge
    scen("R7", 0, 0, 0, 1, 0, 500, 200, 0, 0, fr, fw, nr, nw);
    check("R7", fr, 456);
    scen("R7", 0, 0, 0, 1, 0, 600, 256, 0, 0, fr, fw, nr, nw);
    check("R7", fr, 512);
    // R8: disabled with ticks present
    cur_req = "R8";
    @(negedge clk); en = 1'b0; src_sel = 2'd0; osc_tick = 1'b1; nr = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (rst_req || wake_req) nr++;
    end
    check("R8", nr, 0);
    // R9: select change restarts
    scen("R9", 0, 0, 0, 1, 1, 500, 0, 100, 2, fr, fw, nr, nw);
    check("R9", fr, 356);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule